// File: doc/BRIEF.md
# PHY Reset and Power-Down Controller

This block is the management-side control logic of a single-port 10/100 Ethernet transceiver. Whenever the hardware reset input is active, it samples a set of configuration strap inputs and loads them into the control register and the auto-negotiation advertisement register. It also keeps a private shadow copy of the values it sampled. A software reset is started by writing the control register's self-clearing reset bit. It restores the register contents from that shadow copy and does not look at the strap pins again. Registers stay readable while the software reset runs.

Power can be reduced in two ways. A control-register bit switches off only the network port, and register access keeps working. A hardware power-down pin switches off the port and its clock, tristates the outputs, disables the weak pull resistors and blocks all register access. When auto-negotiation is off, one of four forced link modes takes effect at once. When it is on, the block gives a one-cycle start pulse to the negotiation engine. Register access uses a plain parallel port with an address, write data, and read and write strobes.

Top module: `phy_rstpd_ctrl`

## Requirements
- R1: While hardware reset is active, the control register (address 0) loads the straps: bit 13 = speed strap, bit 12 = auto-negotiation strap, bit 8 = duplex strap, and bits 15 and 11 = 0. Address 4 loads its ability bits [8:5] from the ability straps. Every other bit reads 0.
- R2: Writing address 0 with bit 15 = 1 starts a software reset. Bit 15 then reads 1 for exactly SWRST_CYCLES cycles after the write edge and then reads 0. The network port is disabled while the reset runs.
- R3: A write with bit 15 = 1 during a running software reset restarts the full SWRST_CYCLES count from that write.
- R4: A software reset reloads the speed, auto-negotiation, duplex and ability fields from the values captured at the last hardware reset, and it clears bit 11. Strap changes made since that hardware reset have no effect. Writes that do not set bit 15 are ignored while the reset runs.
- R5: Reads return the current register contents while the software reset runs.
- R6: Control bit 11 = 1 disables the network port (port_en = 0) while clk_en and out_en stay 1. Register reads and writes keep working.
- R7: While hw_pwrdn = 1: port_en = 0, clk_en = 0, out_en = 0, pull_dis = 1, reads return 0 and writes are ignored.
- R8: Leaving hardware power-down without a hardware reset keeps the register contents held before power-down.
- R9: When the port is enabled and bit 12 = 0, link_forced = 1, with link_speed100 = bit 13 and link_full_dup = bit 8. This gives exactly four modes: 100 full, 100 half, 10 full, 10 half. Otherwise all three outputs are 0.
- R10: an_start is a single-cycle pulse. It is raised when the port becomes enabled with bit 12 = 1, or when bit 12 goes to 1 while the port is enabled.
- R11: The hardware reset asserts asynchronously and deasserts after two clock edges. It disables the port at once, aborts a running software reset, and loads the straps even while hw_pwrdn = 1.
- R12: In address 4, bits [4:0] always read 00001 and only bits [8:5] are writable. Bits 5, 6, 7 and 8 advertise 10 half, 10 full, 100 half and 100 full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous assertion |
| strap_speed100 | input | 1 | Speed strap (1 = 100 Mb/s) |
| strap_full_dup | input | 1 | Duplex strap (1 = full) |
| strap_an_en | input | 1 | Auto-negotiation enable strap |
| strap_abil | input | 4 | Advertised ability straps (10H, 10F, 100H, 100F) |
| hw_pwrdn | input | 1 | Hardware power-down pin |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data (0 when not reading) |
| port_en | output | 1 | Network port enable |
| clk_en | output | 1 | Port clock enable |
| out_en | output | 1 | Output drivers enable (0 = tristate) |
| pull_dis | output | 1 | Weak pull-resistor disable |
| link_forced | output | 1 | Forced link mode in effect |
| link_speed100 | output | 1 | Forced speed is 100 Mb/s |
| link_full_dup | output | 1 | Forced mode is full duplex |
| an_start | output | 1 | Auto-negotiation start pulse |

## Verification
A corrupted shadow copy stays hidden until the next software reset. It then shows up in the first register read after the reset-starting write edge, and in the link outputs once bit 15 clears. A wrong reset-timer count moves the cycle in which bit 15 reads 0, so it shows within SWRST_CYCLES cycles of the start. A stuck power-down or auto-negotiation state shows at once on port_en, link_forced or an_start, in the same cycle as the write or pin change that should have changed it.

// File: rtl/phy_rstpd_pkg.sv
package phy_rstpd_pkg;

  typedef struct packed {
    logic spd;   // 1 = 100 Mb/s
    logic an;    // auto-negotiation enable
    logic pd;    // software power-down
    logic dup;   // 1 = full duplex
  } ctrl_t;

  typedef enum logic [2:0] {
    MODE_AUTO  = 3'd0,
    MODE_100FD = 3'd1,
    MODE_100HD = 3'd2,
    MODE_10FD  = 3'd3,
    MODE_10HD  = 3'd4
  } link_mode_e;

  localparam int CTRL_ADDR = 0;
  localparam int ADV_ADDR  = 4;
  localparam logic [4:0] ADV_SELECTOR = 5'b00001;

  function automatic logic [15:0] ctrl_word(input logic busy, input ctrl_t c);
    logic [15:0] w;
    w = '0;
    w[15] = busy;
    w[13] = c.spd;
    w[12] = c.an;
    w[11] = c.pd;
    w[8]  = c.dup;
    return w;
  endfunction

  function automatic logic [15:0] adv_word(input logic [3:0] abil);
    return {7'b0, abil, ADV_SELECTOR};
  endfunction

  function automatic ctrl_t ctrl_from_word(input logic [15:0] w);
    ctrl_t c;
    c.spd = w[13];
    c.an  = w[12];
    c.pd  = w[11];
    c.dup = w[8];
    return c;
  endfunction

  function automatic link_mode_e forced_mode(input ctrl_t c);
    if (c.an) return MODE_AUTO;
    case ({c.spd, c.dup})
      2'b11:   return MODE_100FD;
      2'b10:   return MODE_100HD;
      2'b01:   return MODE_10FD;
      default: return MODE_10HD;
    endcase
  endfunction

endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic hw_rst_n,
  output logic rst_active
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_active = ~sync_q[STAGES-1];
endmodule

// File: rtl/phy_swrst_timer.sv
module phy_swrst_timer #(
  parameter int SWRST_CYCLES = 16,
  localparam int CNT_W = (SWRST_CYCLES < 2) ? 1 : $clog2(SWRST_CYCLES)
) (
  input  logic clk,
  input  logic hw_rst_n,
  input  logic rst_active,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (rst_active) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(SWRST_CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/phy_cfg_regs.sv
module phy_cfg_regs
  import phy_rstpd_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              rst_active,
  input  logic              strap_speed100,
  input  logic              strap_full_dup,
  input  logic              strap_an_en,
  input  logic [3:0]        strap_abil,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              swrst_busy,
  input  logic              swrst_start,
  output ctrl_t             ctrl,
  output logic [3:0]        abil
);
  ctrl_t      shadow_ctrl;
  logic [3:0] shadow_abil;
  logic       wr_ctrl, wr_adv;

  assign wr_ctrl = wr_ok && (addr == ADDR_W'(CTRL_ADDR)) && !swrst_busy;
  assign wr_adv  = wr_ok && (addr == ADDR_W'(ADV_ADDR))  && !swrst_busy;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      ctrl        <= '0;
      abil        <= '0;
      shadow_ctrl <= '0;
      shadow_abil <= '0;
    end else if (rst_active) begin
      ctrl.spd        <= strap_speed100;
      ctrl.an         <= strap_an_en;
      ctrl.pd         <= 1'b0;
      ctrl.dup        <= strap_full_dup;
      abil            <= strap_abil;
      shadow_ctrl.spd <= strap_speed100;
      shadow_ctrl.an  <= strap_an_en;
      shadow_ctrl.pd  <= 1'b0;
      shadow_ctrl.dup <= strap_full_dup;
      shadow_abil     <= strap_abil;
    end else if (swrst_start) begin
      ctrl <= shadow_ctrl;
      abil <= shadow_abil;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_from_word(wdata);
      if (wr_adv)  abil <= wdata[8:5];
    end
  end
endmodule

// File: rtl/phy_rstpd_ctrl.sv
module phy_rstpd_ctrl
  import phy_rstpd_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int SWRST_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              hw_rst_n,
  input  logic              strap_speed100,
  input  logic              strap_full_dup,
  input  logic              strap_an_en,
  input  logic [3:0]        strap_abil,
  input  logic              hw_pwrdn,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [15:0]       reg_rdata,
  output logic              port_en,
  output logic              clk_en,
  output logic              out_en,
  output logic              pull_dis,
  output logic              link_forced,
  output logic              link_speed100,
  output logic              link_full_dup,
  output logic              an_start
);
  // named internal events (observed by the bound checker)
  logic       rst_active;
  logic       swrst_busy;
  logic       swrst_start;
  logic       wr_ok;
  logic       an_run_q;
  logic       ctrl_spd;
  logic       an_en;
  ctrl_t      ctrl;
  logic [3:0] abil;
  link_mode_e mode;

  phy_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .hw_rst_n(hw_rst_n), .rst_active(rst_active)
  );

  assign wr_ok       = reg_wr && !hw_pwrdn && !rst_active;
  assign swrst_start = wr_ok && (reg_addr == ADDR_W'(CTRL_ADDR)) && reg_wdata[15];

  phy_swrst_timer #(.SWRST_CYCLES(SWRST_CYCLES)) u_timer (
    .clk(clk), .hw_rst_n(hw_rst_n), .rst_active(rst_active),
    .start(swrst_start), .busy(swrst_busy)
  );

  phy_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .hw_rst_n(hw_rst_n), .rst_active(rst_active),
    .strap_speed100(strap_speed100), .strap_full_dup(strap_full_dup),
    .strap_an_en(strap_an_en), .strap_abil(strap_abil),
    .wr_ok(wr_ok), .addr(reg_addr), .wdata(reg_wdata),
    .swrst_busy(swrst_busy), .swrst_start(swrst_start),
    .ctrl(ctrl), .abil(abil)
  );

  assign ctrl_spd = ctrl.spd;
  assign an_en    = ctrl.an;
  assign mode     = forced_mode(ctrl);

  // power control
  assign clk_en   = !hw_pwrdn;
  assign out_en   = !hw_pwrdn;
  assign pull_dis = hw_pwrdn;
  assign port_en  = !rst_active && !hw_pwrdn && !ctrl.pd && !swrst_busy;

  // link mode outputs
  assign link_forced   = port_en && (mode != MODE_AUTO);
  assign link_speed100 = link_forced && (mode == MODE_100FD || mode == MODE_100HD);
  assign link_full_dup = link_forced && (mode == MODE_100FD || mode == MODE_10FD);

  // auto-negotiation start: rising edge of "port enabled with AN on"
  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) an_run_q <= 1'b0;
    else           an_run_q <= port_en && ctrl.an;
  end
  assign an_start = port_en && ctrl.an && !an_run_q;

  // read port
  always_comb begin
    reg_rdata = '0;
    if (reg_rd && !hw_pwrdn) begin
      if (reg_addr == ADDR_W'(CTRL_ADDR))     reg_rdata = ctrl_word(swrst_busy, ctrl);
      else if (reg_addr == ADDR_W'(ADV_ADDR)) reg_rdata = adv_word(abil);
    end
  end
endmodule

// File: rtl/phy_rstpd_chk.sv
module phy_rstpd_chk #(
  parameter int SWRST_CYCLES = 16
) (
  input logic        clk,
  input logic        hw_rst_n,
  input logic        rst_active,
  input logic        swrst_busy,
  input logic        swrst_start,
  input logic        hw_pwrdn,
  input logic        port_en,
  input logic        clk_en,
  input logic        out_en,
  input logic        pull_dis,
  input logic [15:0] reg_rdata,
  input logic        link_forced,
  input logic        an_en,
  input logic        an_start,
  input logic        strap_speed100,
  input logic        ctrl_spd
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n)        busy_len <= 0;
    else if (swrst_start) busy_len <= 1;
    else if (swrst_busy)  busy_len <= busy_len + 1;
    else                  busy_len <= 0;
  end

  p_hwpd_pins_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
    hw_pwrdn |-> (!port_en && !clk_en && !out_en && pull_dis));

  p_hwpd_read_zero_r7: assert property (@(posedge clk) disable iff (!hw_rst_n)
    hw_pwrdn |-> (reg_rdata == 16'h0000));

  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
    swrst_start |=> swrst_busy);

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!hw_rst_n)
    swrst_busy |-> (busy_len <= SWRST_CYCLES));

  p_busy_end_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
    ($fell(swrst_busy) && !$past(rst_active)) |-> ($past(busy_len) == SWRST_CYCLES));

  p_busy_blocks_port_r2: assert property (@(posedge clk) disable iff (!hw_rst_n)
    swrst_busy |-> !port_en);

  p_forced_link_r9: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (port_en && !an_en) |-> link_forced);

  p_an_pulse_r10: assert property (@(posedge clk) disable iff (!hw_rst_n)
    an_start |=> !an_start);

  p_strap_load_r1: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (rst_active && hw_rst_n) |=> (ctrl_spd == $past(strap_speed100)));

  p_rst_blocks_port_r11: assert property (@(posedge clk) disable iff (!hw_rst_n)
    rst_active |-> (!port_en && !swrst_busy));
endmodule

bind phy_rstpd_ctrl phy_rstpd_chk #(.SWRST_CYCLES(SWRST_CYCLES)) u_chk (.*);

// File: tb/phy_rstpd_ctrl_tb.sv
`timescale 1ns/1ps
module phy_rstpd_ctrl_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        hw_rst_n = 1'b0;
  logic        strap_speed100 = 1'b1, strap_full_dup = 1'b1, strap_an_en = 1'b0;
  logic [3:0]  strap_abil = 4'b1111;
  logic        hw_pwrdn = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        port_en, clk_en, out_en, pull_dis;
  logic        link_forced, link_speed100, link_full_dup, an_start;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phy_rstpd_ctrl #(.SWRST_CYCLES(N)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #0.2 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {wdata, forced, speed100, full_dup, an_start}
  typedef struct packed {
    logic [15:0] wd;
    logic        f, s, d, a;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{16'h2100, 1'b1, 1'b1, 1'b1, 1'b0},
    '{16'h2000, 1'b1, 1'b1, 1'b0, 1'b0},
    '{16'h0100, 1'b1, 1'b0, 1'b1, 1'b0},
    '{16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h1000, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    // hardware reset with straps 100 full, AN off, all abilities
    repeat (3) @(negedge clk);
    chk("R11 port off in reset", port_en, 0);
    hw_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(0, d); chk("R1 ctrl from straps", d, 16'h2100);
    rd(4, d); chk("R1/R12 adv from straps", d, 16'h01E1);
    chk("R9 forced 100FD", {link_forced, link_speed100, link_full_dup}, 3'b111);
    chk("R7 pins normal", {port_en, clk_en, out_en, pull_dis}, 4'b1110);

    // table: four forced modes then auto-negotiation
    foreach (VEC[i]) begin
      wr(0, VEC[i].wd);
      @(negedge clk);
      chk("R9 link mode", {link_forced, link_speed100, link_full_dup}, {VEC[i].f, VEC[i].s, VEC[i].d});
      chk("R10 an_start on AN enable", an_start, VEC[i].a);
      rd(0, d); chk("R9 ctrl readback", d, VEC[i].wd);
    end
    @(negedge clk);
    chk("R10 single cycle pulse", an_start, 0);

    // R12: selector read-only, abilities writable
    wr(4, 16'h001F);
    rd(4, d); chk("R12 selector fixed", d, 16'h0001);
    wr(0, 16'h0000);
    wr(4, 16'h0021);
    rd(4, d); chk("R12 ability write", d, 16'h0021);

    // software reset ignores new straps
    strap_speed100 = 1'b0; strap_full_dup = 1'b0; strap_an_en = 1'b1; strap_abil = 4'b0000;
    wr(0, 16'h8000);
    rd(0, d); chk("R2/R4/R5 ctrl during swrst", d, 16'hA100);
    rd(4, d); chk("R4/R5 adv during swrst", d, 16'h01E1);
    chk("R2 port off during swrst", port_en, 0);
    wr(0, 16'h0000);
    rd(0, d); chk("R4 write ignored during swrst", d, 16'hA100);
    wr(0, 16'h8000);
    repeat (N-1) @(posedge clk);
    #1 rd(0, d); chk("R3 restart still busy", d[15], 1);
    @(posedge clk);
    #1 rd(0, d); chk("R2 busy cleared", d, 16'h2100);
    chk("R4 port back", {port_en, link_forced, link_speed100, link_full_dup}, 4'b1111);

    // software power-down
    wr(0, 16'h2900);
    @(negedge clk);
    chk("R6 sw pwrdn pins", {port_en, clk_en, out_en, pull_dis, link_forced}, 5'b01100);
    rd(0, d); chk("R6 ctrl readable", d, 16'h2900);
    wr(4, 16'h0041);
    rd(4, d); chk("R6 adv writable", d, 16'h0041);
    wr(0, 16'h2100);
    @(negedge clk);
    chk("R6 port back", port_en, 1);

    // hardware power-down
    @(negedge clk); hw_pwrdn = 1'b1;
    #0.5 chk("R7 hw pwrdn pins", {port_en, clk_en, out_en, pull_dis}, 4'b0001);
    rd(0, d); chk("R7 read zero", d, 16'h0000);
    wr(0, 16'h0000);
    @(negedge clk); hw_pwrdn = 1'b0;
    #0.5 rd(0, d); chk("R8 ctrl kept", d, 16'h2100);
    rd(4, d); chk("R8 adv kept", d, 16'h0041);
    chk("R8 port on", port_en, 1);

    // AN start after leaving hardware power-down
    wr(0, 16'h1000);
    @(negedge clk); hw_pwrdn = 1'b1;
    @(negedge clk);
    chk("R10 no pulse in pwrdn", an_start, 0);
    hw_pwrdn = 1'b0;
    #0.5 chk("R10 pulse on wake", an_start, 1);
    @(posedge clk);
    #1 chk("R10 pulse ends", an_start, 0);

    // hardware reset aborts software reset, loads straps under pwrdn
    strap_speed100 = 1'b0; strap_full_dup = 1'b1; strap_an_en = 1'b0; strap_abil = 4'b0101;
    wr(0, 16'h8000);
    @(negedge clk);
    hw_pwrdn = 1'b1; hw_rst_n = 1'b0;
    #0.5 chk("R11 port off async", port_en, 0);
    @(negedge clk); hw_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    hw_pwrdn = 1'b0;
    #0.5 rd(0, d); chk("R11 straps loaded, swrst aborted", d, 16'h0100);
    rd(4, d); chk("R11 adv straps", d, 16'h00A1);
    chk("R11 forced 10FD", {port_en, link_forced, link_speed100, link_full_dup}, 4'b1101);

    done = 1'b1;
    finish_run();
  end
endmodule